// File: doc/BRIEF.md
# Reset Boot Mode Capture Latch

This block records a two-bit boot mode from a pair of strap pins while the chip's reset pin is held low. It hands the value to the boot logic at the start of the third reset phase. It runs on the internal RC-oscillator clock. It sees the reset pin as an already synchronized level, and it takes two kinds of internal reset request. A pin request makes the block pull the reset pin low itself. A soft request runs a reset sequence that leaves the pin alone.

After a pin request ends, a down-counter keeps the reset pin low for a fixed number of cycles. Strap sampling stops once that counter enters its last few counts, so the straps are no longer sampled as the release edge approaches. The captured mode survives later soft resets, which reuse it without looking at the straps again. A reset that pulls the pin low, whether from the block or from outside, opens a fresh sampling window.

Top module: `boot_mode_capture`

## Requirements
- R1: After power-on reset (`rst_n` low), `boot_mode_o` is 2'b00, `phase3_o` is 0 and `rst_pin_drive_o` is 0. A soft reset before any pin reset therefore delivers 2'b00.
- R2: A pin request (`pin_rst_req_i` high) sets `rst_pin_drive_o` from the next cycle. The drive stays set for exactly HOLD_CYCLES (default 16) cycles after the last cycle in which the request was high, and is then released.
- R3: The strap pins pass through a two-flop synchronizer. While the reset pin is low they are captured every cycle, so a value held since before the request is the one delivered.
- R4: During a block-driven release, sampling stops when the hold counter reaches GUARD_CYCLES (default 5) or fewer remaining counts. A strap change presented at cycle j after the request ends (cycle 0 being the first cycle with the request low) is captured only if j <= HOLD_CYCLES - GUARD_CYCLES - 3.
- R5: `phase3_o` is a single-cycle pulse. It appears one cycle after the reset pin is seen high again, or one cycle after a soft request falls while the pin is high.
- R6: `boot_mode_o` changes only on the cycle in which `phase3_o` is high, and then shows the captured value. It holds that value until the next pulse.
- R7: A soft request (`soft_rst_req_i`) does not resample the straps. The pulse it produces delivers the previously captured mode, whatever the straps show.
- R8: An externally held reset pin, with the block not driving, is sampled on every cycle it is low. The value delivered is the strap value held across the end of that window.
- R9: Soft requests and external pin resets never set `rst_pin_drive_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC-oscillator clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| rst_pin_i | input | 1 | Synchronized reset-pin level, low = asserted |
| pin_rst_req_i | input | 1 | Internal reset request that pulls the pin low |
| soft_rst_req_i | input | 1 | Internal reset sequence without pin assertion |
| boot_pins_i | input | 2 | Boot strap pins |
| rst_pin_drive_o | output | 1 | High = block pulls the reset pin low |
| boot_mode_o | output | 2 | Boot mode handed to the boot logic |
| phase3_o | output | 1 | One-cycle strobe at the start of reset phase 3 |

## Verification
Pin-driven resets change the straps at a random point after the request ends. The points next to the guard boundary are also tried on purpose, and this separates a sampling window that closes at the right count from one that closes a cycle early or late. Soft resets run with straps that differ from the held value, which shows whether the latch resamples when it should only reuse. External pin resets of random length show whether sampling is tied to the pin level or to the block's own counter. The drive length and the strobe position are counted on every pin reset.

// File: rtl/bmc_pkg.sv
// Package: shared helpers for the boot mode capture latch.
// Assumes: counts are small positive integers.
package bmc_pkg;
    // Width of a counter that must hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/bmc_pin_sync.sv
// Module: multi-stage synchronizer for the boot strap pins.
// Assumes: the straps are quasi-static, so bit skew across stages is harmless.
module bmc_pin_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first flop takes the asynchronous pin value.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_i;
            end
        end else begin : g_next
            // Purpose: each further flop lowers the chance of metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bmc_release_timer.sv
// Module: reset-pin hold counter and sampling guard.
// Assumes: the pin request is level; the counter reloads while it stays high.
module bmc_release_timer
    import bmc_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES  = 16,
    parameter int unsigned GUARD_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic drive_o,
    output logic guard_o
);
    localparam int unsigned CW = cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] HOLD_C  = CW'(HOLD_CYCLES);
    localparam logic [CW-1:0] GUARD_C = CW'(GUARD_CYCLES);

    logic [CW-1:0] cnt_q;

    // Purpose: reload while requested, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (req_i)        cnt_q <= HOLD_C;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign drive_o = (cnt_q != '0);
    assign guard_o = (cnt_q != '0) && (cnt_q <= GUARD_C);
endmodule

// File: rtl/bmc_mode_latch.sv
// Module: capture register, phase-3 strobe and published boot mode.
// Assumes: rst_pin_i is already synchronized; low means reset asserted.
module bmc_mode_latch #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_pin_i,
    input  logic             soft_req_i,
    input  logic             guard_i,
    input  logic [WIDTH-1:0] pins_s_i,
    output logic [WIDTH-1:0] mode_o,
    output logic             phase3_o
);
    logic [WIDTH-1:0] cap_q;
    logic [WIDTH-1:0] mode_q;
    logic             pin_prev_q;
    logic             soft_prev_q;
    logic             phase3_q;
    logic             sample_en;
    logic             p3_start;

    assign sample_en = !rst_pin_i && !guard_i;
    assign p3_start  = (rst_pin_i && !pin_prev_q) ||
                       (rst_pin_i && soft_prev_q && !soft_req_i);

    // Purpose: capture the synchronized straps inside the sampling window.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_q <= '0;
        else if (sample_en) cap_q <= pins_s_i;
    end

    // Purpose: remember last pin level and soft request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev_q  <= 1'b1;
            soft_prev_q <= 1'b0;
        end else begin
            pin_prev_q  <= rst_pin_i;
            soft_prev_q <= soft_req_i;
        end
    end

    // Purpose: raise the phase-3 strobe and publish the mode together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase3_q <= 1'b0;
            mode_q   <= '0;
        end else begin
            phase3_q <= p3_start;
            if (p3_start) mode_q <= cap_q;
        end
    end

    assign mode_o   = mode_q;
    assign phase3_o = phase3_q;
endmodule

// File: rtl/boot_mode_capture.sv
// Module: top of the reset boot mode capture latch.
// Assumes: rst_pin_i already includes the effect of rst_pin_drive_o on the pad.
module boot_mode_capture #(
    parameter int unsigned HOLD_CYCLES  = 16,
    parameter int unsigned GUARD_CYCLES = 5,
    parameter int unsigned MODE_W       = 2,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin_i,
    input  logic              pin_rst_req_i,
    input  logic              soft_rst_req_i,
    input  logic [MODE_W-1:0] boot_pins_i,
    output logic              rst_pin_drive_o,
    output logic [MODE_W-1:0] boot_mode_o,
    output logic              phase3_o
);
    logic [MODE_W-1:0] pins_s;
    logic              guard;

    bmc_pin_sync #(.WIDTH(MODE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (boot_pins_i),
        .q_o   (pins_s)
    );

    bmc_release_timer #(.HOLD_CYCLES(HOLD_CYCLES), .GUARD_CYCLES(GUARD_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pin_rst_req_i),
        .drive_o (rst_pin_drive_o),
        .guard_o (guard)
    );

    bmc_mode_latch #(.WIDTH(MODE_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_pin_i  (rst_pin_i),
        .soft_req_i (soft_rst_req_i),
        .guard_i    (guard),
        .pins_s_i   (pins_s),
        .mode_o     (boot_mode_o),
        .phase3_o   (phase3_o)
    );
endmodule

// File: rtl/boot_mode_capture_chk.sv
// Module: assertion checker for boot_mode_capture, attached by bind.
// Assumes: the same clock and synchronous reset as the checked block.
module boot_mode_capture_chk #(
    parameter int unsigned MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rst_pin_i,
    input logic              pin_rst_req_i,
    input logic              soft_rst_req_i,
    input logic              rst_pin_drive_o,
    input logic [MODE_W-1:0] boot_mode_o,
    input logic              phase3_o
);
    AST_DRIVE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rst_req_i |=> rst_pin_drive_o); // R2
    AST_STROBE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pin_i) |=> phase3_o); // R5
    AST_STROBE_ON_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(soft_rst_req_i) && rst_pin_i) |=> phase3_o); // R5
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !phase3_o |-> $stable(boot_mode_o)); // R6
    AST_NO_DRIVE_UNREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pin_rst_req_i) && !$past(rst_pin_drive_o)) |-> !rst_pin_drive_o); // R9
endmodule

bind boot_mode_capture boot_mode_capture_chk #(.MODE_W(MODE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .rst_pin_i       (rst_pin_i),
    .pin_rst_req_i   (pin_rst_req_i),
    .soft_rst_req_i  (soft_rst_req_i),
    .rst_pin_drive_o (rst_pin_drive_o),
    .boot_mode_o     (boot_mode_o),
    .phase3_o        (phase3_o)
);

// File: tb/sim_boot_mode_capture.sv
// Bench: random and directed resets of three kinds against a bench model.
module sim_boot_mode_capture;
    localparam int HOLD  = 16;
    localparam int GUARD = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_req = 1'b0;
    logic       soft_req = 1'b0;
    logic       ext_low = 1'b0;
    logic [1:0] pins = 2'b00;
    logic       drive;
    logic [1:0] mode;
    logic       phase3;
    logic       rst_pin;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_mode = 2'b00;

    assign rst_pin = !(ext_low || drive);

    always #4 clk = ~clk;

    boot_mode_capture u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .rst_pin_i       (rst_pin),
        .pin_rst_req_i   (pin_req),
        .soft_rst_req_i  (soft_req),
        .boot_pins_i     (pins),
        .rst_pin_drive_o (drive),
        .boot_mode_o     (mode),
        .phase3_o        (phase3)
    );

    function automatic logic [1:0] exp_capture(input logic [1:0] a, input logic [1:0] b, input int j);
        return (j <= HOLD - GUARD - 3) ? b : a;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // Pin reset: straps a during request, b from cycle j after it ends.
    task automatic pin_reset(input logic [1:0] a, input logic [1:0] b, input int j);
        int drive_cnt = 0;
        int p3_ok = 1;
        int held = 1;
        logic [1:0] want;
        pins = a;
        pin_req = 1'b1;
        tick();
        check("R2 drive after request", int'(drive), 1);
        repeat (3) tick();
        pin_req = 1'b0;
        want = exp_capture(a, b, j);
        for (int k = 0; k <= HOLD + 2; k++) begin
            if (k == j) pins = b;
            if (drive) drive_cnt++;
            if (int'(phase3) != ((k == HOLD + 1) ? 1 : 0)) p3_ok = 0;
            if (k <= HOLD && mode != exp_mode) held = 0;
            if (k == HOLD + 1) check("R4 captured mode", int'(mode), int'(want));
            tick();
        end
        check("R2 hold length", drive_cnt, HOLD);
        check("R5 strobe timing", p3_ok, 1);
        check("R6 mode held before strobe", held, 1);
        exp_mode = want;
        repeat (2) tick();
    endtask

    // Soft reset with straps c: must not resample.
    task automatic soft_reset(input logic [1:0] c);
        int drv = 0;
        pins = c;
        repeat (3) tick();
        soft_req = 1'b1;
        tick();
        if (drive) drv = 1;
        soft_req = 1'b0;
        tick();
        if (drive) drv = 1;
        check("R5 soft strobe", int'(phase3), 1);
        check("R7 soft reuses mode", int'(mode), int'(exp_mode));
        tick();
        check("R5 strobe single", int'(phase3), 0);
        check("R9 no drive on soft", drv, 0);
    endtask

    // External pin reset of len cycles with straps d.
    task automatic ext_reset(input logic [1:0] d, input int len);
        int drv = 0;
        pins = d;
        ext_low = 1'b1;
        repeat (len) begin
            tick();
            if (drive) drv = 1;
        end
        ext_low = 1'b0;
        tick();
        check("R8 external strobe", int'(phase3), 1);
        check("R8 external capture", int'(mode), int'(d));
        check("R9 no drive on external", drv, 0);
        exp_mode = d;
        tick();
        check("R5 strobe single ext", int'(phase3), 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset mode", int'(mode), 0);
        check("R1 reset strobe", int'(phase3), 0);
        check("R1 reset drive", int'(drive), 0);
        soft_reset(2'b11);                       // R1 and R7: still 00
        pin_reset(2'b10, 2'b01, HOLD - GUARD - 3); // R4 last capturing cycle
        pin_reset(2'b01, 2'b10, HOLD - GUARD - 2); // R4 first guarded cycle
        pin_reset(2'b11, 2'b00, HOLD - 1);         // R3 value held from request
        soft_reset(2'b01);                       // R7
        ext_reset(2'b10, 6);                     // R8
        soft_reset(2'b00);                       // R7 after external
        for (int t = 0; t < 60; t++) begin
            int kind = int'($urandom_range(2, 0));
            logic [1:0] a = 2'($urandom_range(3, 0));
            logic [1:0] b = 2'($urandom_range(3, 0));
            if (kind == 0) pin_reset(a, b, int'($urandom_range(HOLD - 1, 0)));
            else if (kind == 1) soft_reset(a);
            else ext_reset(a, int'($urandom_range(12, 4)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule